// File: doc/BRIEF.md
# Start/Done Task Composition Sequencer

This block coordinates a fixed set of child tasks. Each child takes a one-cycle start pulse and returns a done level. The level drops after the child is started and rises again when the child's work completes. The sequencer offers the same start/done handshake on its own side, so one instance can serve as a child of another instance. It can therefore be nested to build larger control flows.

A go strobe that arrives while the block is idle selects one of three compositions, taken from the mode input:
- **Chain mode** runs the children one after another. An encoded step counter tracks which child is running.
- **Fan mode** launches every child in the same cycle. It then waits until all of them report done.
- **Repeat mode** reruns child 0. It samples a predicate input at launch and again each time the child finishes.

The block samples the child done inputs only in cycles where none of its start pulses is visible. This means a done level left over from a child's previous run is never taken as a fresh completion.

Top module: `task_sequencer`

## Requirements
- R1: After reset, `done_o` is 1 and no `task_start_o` bit is set.
- R2: `go_i` is accepted only in a cycle where `done_o` is 1. A go strobe while `done_o` is 0 produces no start pulse and does not change the run in progress.
- R3: The first start pulse appears on `task_start_o` in the cycle after the go strobe is accepted.
- R4: In chain mode (`mode_i` = 2'b00), at most one start bit is set at a time. Child k (k > 0) is started only while child k-1 reports done, and each child is started exactly once per run, in index order.
- R5: In chain mode, `done_o` returns to 1 only after the last child reports done.
- R6: In fan mode (`mode_i` = 2'b01), every start bit is set in the same cycle, exactly once per run.
- R7: In fan mode, `done_o` returns to 1 only once all child done inputs are 1.
- R8: In repeat mode (`mode_i` = 2'b10), if `pred_i` is 0 when go is accepted, no child is started and `done_o` stays 1.
- R9: In repeat mode, each time child 0 completes, the block samples `pred_i` again. It restarts child 0 if `pred_i` is 1; otherwise it raises `done_o`. Only child 0 is ever started.
- R10: Every start bit is a single-cycle pulse.
- R11: A go strobe with `mode_i` = 2'b11 is ignored: no start pulse is issued and `done_o` stays 1.
- R12: The composition is fixed when go is accepted. Changing `mode_i` during a run has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start request for the composed task |
| mode_i | input | 2 | Composition select: 00 chain, 01 fan, 10 repeat, 11 reserved |
| pred_i | input | 1 | Repeat-mode continuation predicate |
| task_done_i | input | N_TASKS | Done levels from the children |
| task_start_o | output | N_TASKS | Start pulses to the children |
| done_o | output | 1 | High when the block is idle and ready for go |

## Verification
The collision of interest is a fresh go strobe in the same cycle as a child completion that advances or ends the run. `done_o` is still 0 in that cycle, so the strobe must be dropped (R2). It must not be taken as a new launch once the final step retires.

The bench provokes this in chain mode. It watches for the last child's done level to come back up, then drives go in exactly that cycle. It judges the result from the per-child start counts, which must stay at one each, and from `done_o` settling high with no further pulses. Each vector run also pulses go in the middle of the run and switches `mode_i` to the reserved code right after launch, which exercises R2 and R12 together.

// File: rtl/task_seq_pkg.sv
package task_seq_pkg;

  typedef enum logic [1:0] {
    MODE_CHAIN  = 2'b00,
    MODE_FAN    = 2'b01,
    MODE_REPEAT = 2'b10,
    MODE_NONE   = 2'b11
  } comp_mode_e;

endpackage

// File: rtl/chain_stepper.sv
// Chain composition: an encoded step counter, 0 = idle,
// k = child k-1 launched and awaited.
module chain_stepper #(
  parameter int N_TASKS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic               settled,
  input  logic [N_TASKS-1:0] done_i,
  output logic [N_TASKS-1:0] fire,
  output logic               busy
);
  localparam int PW = $clog2(N_TASKS + 1);

  logic [PW-1:0] step_q, step_d;

  always_comb begin
    fire   = '0;
    step_d = step_q;
    if (launch) begin
      fire[0] = 1'b1;
      step_d  = PW'(1);
    end else if (settled) begin
      // Steps 1 .. N-1: the previous child is done, so launch the next one.
      for (int k = 1; k < N_TASKS; k++) begin
        if (step_q == PW'(k) && done_i[k-1]) begin
          fire[k] = 1'b1;
          step_d  = PW'(k + 1);
        end
      end
      // Final step: wait for the last child before returning to idle.
      if (step_q == PW'(N_TASKS) && done_i[N_TASKS-1]) begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end

  assign busy = (step_q != '0);
endmodule

// File: rtl/fan_join.sv
// Fan composition: launch all children together, join on the AND of dones.
module fan_join #(
  parameter int N_TASKS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic               settled,
  input  logic [N_TASKS-1:0] done_i,
  output logic [N_TASKS-1:0] fire,
  output logic               busy
);
  logic busy_q;

  assign fire = launch ? '1 : '0;
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (rst)                           busy_q <= 1'b0;
    else if (launch)                   busy_q <= 1'b1;
    else if (busy_q && settled && &done_i) busy_q <= 1'b0;
  end
endmodule

// File: rtl/repeat_ctrl.sv
// Repeat composition: rerun one child while the predicate holds.
module repeat_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic settled,
  input  logic pred,
  input  logic body_done,
  output logic fire,
  output logic busy
);
  logic busy_q, busy_d;
  logic retest;

  assign retest = busy_q && settled && body_done;

  always_comb begin
    fire   = 1'b0;
    busy_d = busy_q;
    if (launch || retest) begin
      fire   = pred;
      busy_d = pred;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy_d;
  end

  assign busy = busy_q;
endmodule

// File: rtl/task_sequencer.sv
module task_sequencer
  import task_seq_pkg::*;
#(
  parameter int N_TASKS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go_i,
  input  logic [1:0]         mode_i,
  input  logic               pred_i,
  input  logic [N_TASKS-1:0] task_done_i,
  output logic [N_TASKS-1:0] task_start_o,
  output logic               done_o
);
  logic [N_TASKS-1:0] start_q, start_d;
  comp_mode_e         mode_q, sel_mode, req_mode;
  logic               accept, settled;
  logic               chain_busy, fan_busy, rep_busy;
  logic [N_TASKS-1:0] chain_fire, fan_fire;
  logic               rep_fire;

  assign req_mode = comp_mode_e'(mode_i);
  assign done_o   = !(chain_busy || fan_busy || rep_busy);
  assign accept   = go_i && done_o && (req_mode != MODE_NONE);
  // A done level is trusted only when no start pulse is on the wires.
  assign settled  = ~|start_q;
  assign sel_mode = accept ? req_mode : mode_q;

  chain_stepper #(.N_TASKS(N_TASKS)) u_chain (
    .clk(clk), .rst(rst),
    .launch(accept && req_mode == MODE_CHAIN),
    .settled(settled), .done_i(task_done_i),
    .fire(chain_fire), .busy(chain_busy)
  );

  fan_join #(.N_TASKS(N_TASKS)) u_fan (
    .clk(clk), .rst(rst),
    .launch(accept && req_mode == MODE_FAN),
    .settled(settled), .done_i(task_done_i),
    .fire(fan_fire), .busy(fan_busy)
  );

  repeat_ctrl u_rep (
    .clk(clk), .rst(rst),
    .launch(accept && req_mode == MODE_REPEAT),
    .settled(settled), .pred(pred_i), .body_done(task_done_i[0]),
    .fire(rep_fire), .busy(rep_busy)
  );

  always_comb begin
    case (sel_mode)
      MODE_CHAIN:  start_d = chain_fire;
      MODE_FAN:    start_d = fan_fire;
      MODE_REPEAT: start_d = N_TASKS'(rep_fire);
      default:     start_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      mode_q  <= MODE_NONE;
    end else begin
      start_q <= start_d;
      if (accept) mode_q <= req_mode;
    end
  end

  assign task_start_o = start_q;
endmodule

// File: rtl/task_sequencer_chk.sv
module task_sequencer_chk #(
  parameter int N_TASKS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               go_i,
  input logic               done_o,
  input logic [N_TASKS-1:0] task_start_o,
  input logic [N_TASKS-1:0] task_done_i,
  input logic [1:0]         mode_q
);
  p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (|task_start_o) |=> ((task_start_o & $past(task_start_o)) == '0));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (done_o && !go_i) |=> (task_start_o == '0));

  p_mode_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> $stable(mode_q));

  p_chain_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b00) |-> $onehot0(task_start_o));

  p_fan_all_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b01 && |task_start_o) |-> (&task_start_o));

  p_join_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(done_o) && mode_q != 2'b10) |-> (&task_done_i));

  p_repeat_body_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b10) |-> (task_start_o[N_TASKS-1:1] == '0));
endmodule

bind task_sequencer task_sequencer_chk #(.N_TASKS(N_TASKS)) u_chk (
  .clk(clk), .rst(rst), .go_i(go_i), .done_o(done_o),
  .task_start_o(task_start_o), .task_done_i(task_done_i),
  .mode_q(mode_q)
);

// File: tb/task_sequencer_tb_top.sv
module task_sequencer_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         go_i = 1'b0;
  logic [1:0]   mode_i = 2'b11;
  logic         pred_i;
  logic [N-1:0] c_done;
  logic [N-1:0] task_start_o;
  logic         done_o;

  logic [3:0]   lat [N];
  logic [3:0]   c_cnt [N];
  int           seen [N];
  int           loop_target = 0;
  logic         clr = 1'b1;
  logic [1:0]   run_mode = 2'b11;
  logic [N-1:0] prev_start = '0;
  int           checks = 0;
  int           fails = 0;
  int           cyc = 0;

  always #10 clk = ~clk;  // 50 MHz

  task_sequencer #(.N_TASKS(N)) dut_i (
    .clk(clk), .rst(rst), .go_i(go_i), .mode_i(mode_i), .pred_i(pred_i),
    .task_done_i(c_done), .task_start_o(task_start_o), .done_o(done_o)
  );

  assign pred_i = (seen[0] < loop_target);

  // Variable-latency child responders.
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        c_done[i] <= 1'b1;
        c_cnt[i]  <= '0;
      end else if (task_start_o[i]) begin
        c_done[i] <= 1'b0;
        c_cnt[i]  <= lat[i];
      end else if (!c_done[i]) begin
        if (c_cnt[i] <= 4'd1) c_done[i] <= 1'b1;
        else                  c_cnt[i]  <= c_cnt[i] - 4'd1;
      end
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (clr) seen[i] <= 0;
      else if (task_start_o[i]) seen[i] <= seen[i] + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Continuous protocol monitors sampled away from the clock edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (task_start_o != '0) begin
        chk((task_start_o & prev_start) == '0, "R10 start pulse width",
            int'(task_start_o), 0);
        if (run_mode == 2'b00) begin
          chk($onehot(task_start_o), "R4 one start at a time", int'(task_start_o), 1);
          for (int k = 1; k < N; k++)
            if (task_start_o[k])
              chk(c_done[k-1], "R4 predecessor done", int'(c_done[k-1]), 1);
        end
        if (run_mode == 2'b01)
          chk(&task_start_o, "R6 all starts together", int'(task_start_o), 15);
      end
      prev_start <= task_start_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // {mode[37:36], target[35:32], lat3..lat0[31:16], exp3..exp0[15:0]}
  localparam logic [37:0] VEC [8] = '{
    {2'b00, 4'd0, 16'h1321, 16'h1111},
    {2'b00, 4'd0, 16'h4115, 16'h1111},
    {2'b01, 4'd0, 16'h6231, 16'h1111},
    {2'b01, 4'd0, 16'h4444, 16'h1111},
    {2'b10, 4'd3, 16'h1112, 16'h0003},
    {2'b10, 4'd0, 16'h1111, 16'h0000},
    {2'b10, 4'd1, 16'h1111, 16'h0001},
    {2'b11, 4'd0, 16'h1111, 16'h0000}
  };

  task automatic prep(input logic [15:0] lats, input int tgt);
    @(negedge clk);
    for (int i = 0; i < N; i++) lat[i] = lats[4*i +: 4];
    loop_target = tgt;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic run_vec(input logic [37:0] v);
    logic [1:0] m;
    int         total;
    bit         first_ok;
    m = v[37:36];
    prep(v[31:16], int'(v[35:32]));
    total = 0;
    for (int i = 0; i < N; i++) total += int'(v[4*i +: 4]);
    first_ok = (v[3:0] != 4'd0);
    run_mode = m;
    mode_i   = m;
    go_i     = 1'b1;
    @(negedge clk);
    go_i   = 1'b0;
    mode_i = 2'b11;  // R12: mode changes after acceptance
    chk(task_start_o[0] == first_ok, "R3 first start one cycle after go",
        int'(task_start_o[0]), int'(first_ok));
    chk(done_o == (total == 0), "R8 R11 busy after go", int'(done_o), int'(total == 0));
    if (total != 0) begin
      @(negedge clk);
      mode_i = 2'b00;
      go_i   = 1'b1;  // R2: strobe while busy
      @(negedge clk);
      go_i   = 1'b0;
      mode_i = 2'b11;
    end
    while (!done_o) @(negedge clk);
    if (m != 2'b10)
      chk(&c_done, "R5 R7 join before done", int'(c_done), 15);
    repeat (4) @(negedge clk);
    for (int i = 0; i < N; i++)
      chk(seen[i] == int'(v[4*i +: 4]), "R2 R4 R6 R9 R11 R12 start count",
          seen[i], int'(v[4*i +: 4]));
    chk(done_o, "R5 R7 R9 idle after run", int'(done_o), 1);
    run_mode = 2'b11;
  endtask

  initial begin
    for (int i = 0; i < N; i++) lat[i] = 4'd1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(done_o, "R1 done after reset", int'(done_o), 1);
    chk(task_start_o == '0, "R1 no starts after reset", int'(task_start_o), 0);

    for (int t = 0; t < 8; t++) run_vec(VEC[t]);

    // Collision: go in the cycle the last chain child completes (R2).
    prep(16'h3111, 0);
    run_mode = 2'b00;
    mode_i = 2'b00;
    go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    while (!(seen[N-1] == 1 && c_done[N-1])) @(negedge clk);
    go_i = 1'b1;
    chk(!done_o, "R5 still busy when last child completes", int'(done_o), 0);
    @(negedge clk);
    go_i = 1'b0;
    mode_i = 2'b11;
    repeat (6) @(negedge clk);
    for (int i = 0; i < N; i++)
      chk(seen[i] == 1, "R2 go at completion ignored", seen[i], 1);
    chk(done_o, "R5 done after collision", int'(done_o), 1);
    run_mode = 2'b11;

    // Reset in mid run (R1).
    prep(16'h9999, 0);
    run_mode = 2'b00;
    mode_i = 2'b00;
    go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    mode_i = 2'b11;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    run_mode = 2'b11;
    @(negedge clk);
    chk(done_o, "R1 done after mid-run reset", int'(done_o), 1);
    chk(task_start_o == '0, "R1 quiet after mid-run reset", int'(task_start_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule